// File: doc/BRIEF.md
# Gated programmable clock divider

The block divides a parent clock by a programmable integer and gates the result. Two single-cycle write strobes control it: one loads a divisor code, the other sets or clears the run request. A status word shows two busy flags while a divisor change is pending, and a sticky error flag reports a divisor write made while busy. The `active` output reads back whether the divided clock is running.

Two code formats exist, chosen by the `WIDE` parameter. The narrow format is 5 bits: a code n from 1 to 31 divides by n, and code 0 divides by 32. The wide format is 6 bits: with bit 5 clear it works like the narrow format, except that code 0 divides by 64. With bit 5 set, the divisor is 64 times bits 4:0, and a zero in bits 4:0 falls back to 64. Divisor changes and gate changes take effect only at the end of an output period. For divisor 1 the parent clock is passed straight through.

The control state machine has three states. ST_IDLE moves to ST_WAIT when a divisor write is accepted. ST_WAIT stays put until the current output period ends, then loads the new divisor and moves to ST_SETTLE. ST_SETTLE returns to ST_IDLE on the next cycle. The busy flags are set in every state except ST_IDLE.

Top module: `gated_clk_div`

## Requirements
- R1: After reset the divisor is the code-0 value (32 narrow, 64 wide), the output is stopped, `active` is 0 and `status` is all zero.
- R2: Narrow format: code n (1..31) gives an output period of n parent cycles; code 0 gives 32.
- R3: Wide format: with bit 5 clear, code n gives n and code 0 gives 64. With bit 5 set, the divisor is 64 times bits 4:0, and 64 when bits 4:0 are zero.
- R4: For a divisor D of 2 or more, the output is high for floor(D/2) parent cycles and low for the rest of the period.
- R5: With divisor 1 and the gate running, `clk_out` follows the parent clock.
- R6: A new divisor applies from the first period that starts after the current period ends. `status` bits 3 and 4 both read 1 from the cycle after the write until one cycle after the switchover.
- R7: A divisor write made while busy is ignored and sets `status` bit 0. The bit stays set until a cycle with `stat_rd` high, after which it reads 0.
- R8: A gate write applies only at the end of a period. Turning off never cuts a high phase short, turning on starts with a full high phase, and `active` reads 1 exactly while the gate is running.
- R9: `status` bits 1 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_wr | input | 1 | Divisor write strobe |
| div_code | input | 5 (6 when WIDE) | Divisor code |
| gate_wr | input | 1 | Gate write strobe |
| gate_on | input | 1 | Requested gate state, 1 = run |
| stat_rd | input | 1 | Status read strobe; clears the error flag |
| status | output | 5 | Bit 0 error, bits 3 and 4 busy, others 0 |
| clk_out | output | 1 | Divided, gated clock |
| active | output | 1 | 1 while the output clock runs |

## Verification
The in-RTL assertions check on every cycle that the divisor and the gate change only at a period end, and that the output is low when a period ends. They also check that ST_WAIT is held until that boundary and that a write made while busy leaves the error flag set until a read clears it. The bench scenarios cover the rest: the high and low lengths of each divisor in both formats, the exact cycle at which a mid-period change switches over and busy clears, the lack of effect of an ignored write, pass-through at divisor 1, and clean gate on and off edges.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_SETTLE = 2'd2
    } cdiv_state_e;

    function automatic int code_w(bit wide);
        return wide ? 6 : 5;
    endfunction

    function automatic int max_div(bit wide);
        return wide ? 64 * 31 : 32;
    endfunction

    function automatic int div_w(bit wide);
        return $clog2(max_div(wide) + 1);
    endfunction

    // divisor selected by code 0
    function automatic int rst_div(bit wide);
        return wide ? 64 : 32;
    endfunction

endpackage

// File: rtl/cdiv_decode.sv
module cdiv_decode #(
    parameter bit WIDE = 1'b0
) (
    input  logic [cdiv_pkg::code_w(WIDE)-1:0] code,
    output logic [cdiv_pkg::div_w(WIDE)-1:0]  eff
);
    localparam int DIV_W = cdiv_pkg::div_w(WIDE);
    localparam int TOP   = cdiv_pkg::rst_div(WIDE);

    generate
        if (WIDE) begin : g_wide
            always_comb begin
                if (code[5]) begin
                    if (code[4:0] == 5'd0) eff = DIV_W'(TOP);
                    else                   eff = DIV_W'({code[4:0], 6'd0});
                end else if (code == '0) begin
                    eff = DIV_W'(TOP);
                end else begin
                    eff = DIV_W'(code);
                end
            end
        end else begin : g_narrow
            always_comb begin
                if (code == '0) eff = DIV_W'(TOP);
                else            eff = DIV_W'(code);
            end
        end
    endgenerate

endmodule

// File: rtl/cdiv_ctrl.sv
module cdiv_ctrl #(
    parameter bit WIDE = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_div,
    input  logic [cdiv_pkg::div_w(WIDE)-1:0] eff_in,
    input  logic                             rd_stat,
    input  logic                             period_end,
    output logic                             load,
    output logic [cdiv_pkg::div_w(WIDE)-1:0] new_div,
    output logic                             busy,
    output logic                             err
);
    import cdiv_pkg::*;

    localparam int DIV_W = div_w(WIDE);

    cdiv_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (wr_div)     state_nx = ST_WAIT;
            ST_WAIT:   if (period_end) state_nx = ST_SETTLE;
            ST_SETTLE:                 state_nx = ST_IDLE;
            default:                   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        busy = (state != ST_IDLE);
        load = (state == ST_WAIT) && period_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_div <= DIV_W'(rst_div(WIDE));
            err     <= 1'b0;
        end else begin
            if (wr_div && !busy) new_div <= eff_in;
            if (wr_div && busy)  err <= 1'b1;
            else if (rd_stat)    err <= 1'b0;
        end
    end

    a_r6_wait_for_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !period_end) |=> (state == ST_WAIT));

    a_r7_busy_write_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_div && busy) |=> err);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err) && !$past(rd_stat)) |-> err);

endmodule

// File: rtl/cdiv_core.sv
module cdiv_core #(
    parameter bit WIDE = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic [cdiv_pkg::div_w(WIDE)-1:0] new_div,
    input  logic                             gate_wr,
    input  logic                             gate_val,
    output logic                             period_end,
    output logic                             clk_out,
    output logic                             run
);
    import cdiv_pkg::*;

    localparam int DIV_W = div_w(WIDE);
    localparam int RSTD  = rst_div(WIDE);

    logic [DIV_W-1:0] cur_div, cnt, cnt_nx, nd;
    logic             q_r, en_req;
    logic             pass_n, run_n;

    always_comb begin
        period_end = (cnt == cur_div - DIV_W'(1));
        cnt_nx     = cnt + DIV_W'(1);
        nd         = load ? new_div : cur_div;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_div <= DIV_W'(RSTD);
            cnt     <= DIV_W'(RSTD - 1);
            q_r     <= 1'b0;
            run     <= 1'b0;
            en_req  <= 1'b0;
        end else begin
            if (gate_wr) en_req <= gate_val;
            if (period_end) begin
                cnt <= '0;
                q_r <= ((nd >> 1) != '0);
                run <= en_req;
                if (load) cur_div <= new_div;
            end else begin
                cnt <= cnt_nx;
                q_r <= (cnt_nx < (cur_div >> 1));
            end
        end
    end

    // copies taken while the parent clock is low keep the bypass path glitch free
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pass_n <= 1'b0;
            run_n  <= 1'b0;
        end else begin
            pass_n <= (cur_div == DIV_W'(1));
            run_n  <= run;
        end
    end

    assign clk_out = pass_n ? (clk & run_n) : (q_r & run);

    a_r6_div_changes_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_div != $past(cur_div)) |-> $past(load));

    a_r8_gate_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (run != $past(run)) |-> $past(period_end));

    a_r4_low_at_period_end: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && cur_div > DIV_W'(1)) |-> !q_r);

    a_r2_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cur_div != '0);

endmodule

// File: rtl/gated_clk_div.sv
module gated_clk_div #(
    parameter bit WIDE = 1'b0
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              div_wr,
    input  logic [cdiv_pkg::code_w(WIDE)-1:0] div_code,
    input  logic                              gate_wr,
    input  logic                              gate_on,
    input  logic                              stat_rd,
    output logic [4:0]                        status,
    output logic                              clk_out,
    output logic                              active
);
    localparam int DIV_W = cdiv_pkg::div_w(WIDE);

    logic [DIV_W-1:0] eff, new_div;
    logic             load, busy, err, period_end;

    cdiv_decode #(.WIDE(WIDE)) u_decode (
        .code (div_code),
        .eff  (eff)
    );

    cdiv_ctrl #(.WIDE(WIDE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_div     (div_wr),
        .eff_in     (eff),
        .rd_stat    (stat_rd),
        .period_end (period_end),
        .load       (load),
        .new_div    (new_div),
        .busy       (busy),
        .err        (err)
    );

    cdiv_core #(.WIDE(WIDE)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .new_div    (new_div),
        .gate_wr    (gate_wr),
        .gate_val   (gate_on),
        .period_end (period_end),
        .clk_out    (clk_out),
        .run        (active)
    );

    assign status = {busy, busy, 2'b00, err};

endmodule

// File: tb/gated_clk_div_bench.sv
module gated_clk_div_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [5:0] code = '0;
    logic       gate_wr = 1'b0;
    logic       gate_on = 1'b0;
    logic       stat_rd = 1'b0;
    logic [4:0] st_n, st_w;
    logic       co_n, co_w, act_n, act_w;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    gated_clk_div u_gated_clk_div (
        .clk (clk), .rst_n (rst_n), .div_wr (div_wr), .div_code (code[4:0]),
        .gate_wr (gate_wr), .gate_on (gate_on), .stat_rd (stat_rd),
        .status (st_n), .clk_out (co_n), .active (act_n)
    );

    gated_clk_div #(.WIDE(1'b1)) u_wide (
        .clk (clk), .rst_n (rst_n), .div_wr (div_wr), .div_code (code),
        .gate_wr (gate_wr), .gate_on (gate_on), .stat_rd (stat_rd),
        .status (st_w), .clk_out (co_w), .active (act_w)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit outv(input bit w);
        return w ? co_w : co_n;
    endfunction

    task automatic wait_idle();
        for (int g = 0; g < 5000; g++) begin
            if (!st_n[3] && !st_w[3]) return;
            @(negedge clk);
        end
        chk("busy timeout", 1, 0);
    endtask

    task automatic set_div(input logic [5:0] c);
        div_wr = 1'b1; code = c;
        @(negedge clk);
        div_wr = 1'b0;
        @(negedge clk);
        wait_idle();
    endtask

    task automatic set_gate(input bit v);
        gate_wr = 1'b1; gate_on = v;
        @(negedge clk);
        gate_wr = 1'b0;
    endtask

    // returns at the negedge that shows the first high sample of a period
    task automatic sync_rise(input bit w);
        bit prev = outv(w);
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (!prev && outv(w)) return;
            prev = outv(w);
        end
        chk("no rising edge", 1, 0);
    endtask

    task automatic measure(input bit w, output int hi, output int lo);
        sync_rise(w);
        hi = 1; lo = 0;
        @(negedge clk);
        for (int g = 0; g < 5000 && outv(w); g++) begin hi++; @(negedge clk); end
        for (int g = 0; g < 5000 && !outv(w); g++) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset();
        int hi, lo;
        chk("R1 status", int'(st_n), 0);
        chk("R1 active", int'(act_n), 0);
        chk("R1 wide status", int'(st_w), 0);
        chk("R1 clk_out stopped", int'(co_n), 0);
        set_gate(1'b1);
        measure(1'b0, hi, lo);
        chk("R1 R2 code0 high", hi, 16);
        chk("R1 R2 code0 low", lo, 16);
        chk("R1 active running", int'(act_n), 1);
    endtask

    task automatic t_divs();
        int hi, lo;
        int cs[4] = '{3, 4, 7, 31};
        foreach (cs[i]) begin
            set_div(6'(cs[i]));
            measure(1'b0, hi, lo);
            chk($sformatf("R2 R4 high d=%0d", cs[i]), hi, cs[i] / 2);
            chk($sformatf("R2 R4 low d=%0d", cs[i]), lo, cs[i] - cs[i] / 2);
        end
    endtask

    task automatic t_switch();
        logic smp[12];
        logic [1:0] bz[12];
        bit exp_s[12] = '{1, 1, 0, 0, 1, 1, 1, 0, 0, 0, 1, 1};
        set_div(6'd4);
        sync_rise(1'b0);
        div_wr = 1'b1; code = 6'd6;
        for (int i = 0; i < 12; i++) begin
            smp[i] = co_n; bz[i] = st_n[4:3];
            @(negedge clk);
            div_wr = 1'b0;
        end
        for (int i = 0; i < 12; i++)
            chk($sformatf("R6 sample %0d", i), int'(smp[i]), int'(exp_s[i]));
        chk("R6 busy before", int'(bz[0]), 0);
        chk("R6 busy after write", int'(bz[1]), 3);
        chk("R6 busy at switchover", int'(bz[4]), 3);
        chk("R6 busy cleared", int'(bz[5]), 0);
        wait_idle();
    endtask

    task automatic t_busy_write();
        int hi, lo;
        set_div(6'd4);
        div_wr = 1'b1; code = 6'd8;
        @(negedge clk);
        chk("R6 busy seen", int'(st_n[3]), 1);
        code = 6'd2;              // R7 this write lands while busy
        @(negedge clk);
        div_wr = 1'b0;
        chk("R7 err set", int'(st_n[0]), 1);
        chk("R9 spare bits", int'(st_n[2:1]), 0);
        wait_idle();
        measure(1'b0, hi, lo);
        chk("R7 ignored write high", hi, 4);
        chk("R7 ignored write low", lo, 4);
        chk("R7 err sticky", int'(st_n[0]), 1);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk("R7 err cleared", int'(st_n[0]), 0);
    endtask

    task automatic t_gate();
        logic smp[8];
        logic ac[8];
        int hi, lo, highs;
        set_div(6'd4);
        sync_rise(1'b0);
        gate_wr = 1'b1; gate_on = 1'b0;
        for (int i = 0; i < 8; i++) begin
            smp[i] = co_n; ac[i] = act_n;
            @(negedge clk);
            gate_wr = 1'b0;
        end
        chk("R8 high phase kept", int'(smp[1]), 1);
        chk("R8 low before stop", int'(smp[2]), 0);
        chk("R8 active until boundary", int'(ac[3]), 1);
        chk("R8 active off", int'(ac[4]), 0);
        highs = 0;
        for (int i = 0; i < 20; i++) begin highs += int'(co_n); @(negedge clk); end
        chk("R8 stays stopped", highs, 0);
        set_gate(1'b1);
        measure(1'b0, hi, lo);
        chk("R8 first high full", hi, 2);
        chk("R8 restart low", lo, 2);
        chk("R8 active on", int'(act_n), 1);
    endtask

    task automatic t_pass();
        int hi, lo;
        set_div(6'd1);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #2;
            chk("R5 follows high", int'(co_n), 1);
            @(negedge clk); #2;
            chk("R5 follows low", int'(co_n), 0);
        end
        @(negedge clk);
        set_div(6'd4);
        measure(1'b0, hi, lo);
        chk("R5 leave bypass high", hi, 2);
        chk("R5 leave bypass low", lo, 2);
    endtask

    task automatic t_wide();
        int hi, lo;
        int cs[5] = '{0, 'h20, 'h22, 5, 'h21};
        int dv[5] = '{64, 64, 128, 5, 64};
        stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
        foreach (cs[i]) begin
            set_div(6'(cs[i]));
            measure(1'b1, hi, lo);
            chk($sformatf("R3 wide high code=%0h", cs[i]), hi, dv[i] / 2);
            chk($sformatf("R3 wide low code=%0h", cs[i]), lo, dv[i] - dv[i] / 2);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_divs();
        t_switch();
        t_busy_write();
        t_gate();
        t_pass();
        t_wide();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule